// File: doc/BRIEF.md
# Flash Converter Digital Back-End

This block is the digital half of a 6-bit flash analog-to-digital converter. A bank of 64 comparators feeds it a thermometer vector. The block holds that vector at the end of each sample phase and turns it into a binary code plus an overflow flag. It then places the result in output registers.

A result is visible 1.5 clock cycles after the edge that latched its comparators. A polarity input chooses whether sampling happens while the clock is low or while it is high. Changing this choice moves the whole pipeline to the other clock edge.

Two enables set whether the data bits and the overflow bit are driven. They control separate drive-enable outputs for each group, so a pad ring can build the three-state pins. The overflow bit reads as a seventh, higher bit, so two converters can be stacked to give 7 bits of resolution.

The stream carries no handshake. One vector is taken on every latch edge and one result leaves on every output edge, and the block never applies back-pressure. The downstream logic must accept a result every cycle.

Top module: `flash_adc_backend`

## Requirements
- R1: While `rst_n` is low, `code_out` and `ovf_out` read 0.
- R2: Bit k of `therm_in` is comparator k+1. With bit 63 clear, `code_out` is the highest comparator index i (1..63) that is set and whose comparator i-1 is also set. Comparator 1 counts on its own. When no such i exists, the code is 0. A clean thermometer with n ones therefore gives n.
- R3: A single cleared bit inside a run of ones, or a lone set bit above a cleared gap, does not change the code from the top of the run that has a set neighbour below.
- R4: When bit 63 (comparator 64) is set, `code_out` reads 63 and `ovf_out` reads 1. When bit 63 is clear, `ovf_out` reads 0.
- R5: With `sample_inv`=0, comparators are latched on the rising clock edge. The output changes on the falling edge one and a half cycles after that rising edge.
- R6: With `sample_inv`=1, comparators are latched on the falling edge. The output changes on the rising edge one and a half cycles later.
- R7: `data_oe` is 1 only when `drive_en_n`=0 and `drive_en`=1.
- R8: `ovf_oe` equals `drive_en`, whatever the value of `drive_en_n`.
- R9: Both drive enables follow their inputs combinationally. They do not pass through the pipeline.
- R10: A new vector is accepted on every latch edge, and consecutive results appear on consecutive output edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_inv | input | 1 | 0: sample while clock low; 1: sample while clock high |
| therm_in | input | 64 | Comparator outputs, bit k = comparator k+1 |
| drive_en_n | input | 1 | Data drive enable, active low |
| drive_en | input | 1 | Global drive enable, active high |
| code_out | output | 6 | Registered binary code |
| ovf_out | output | 1 | Registered overflow flag |
| data_oe | output | 1 | Drive enable for `code_out` pins |
| ovf_oe | output | 1 | Drive enable for `ovf_out` pin |

## Verification
Some properties are checked on every cycle. These are the enable decoding (the overflow enable depends only on the active-high enable, and the data enable implies it), the rule that an overflow always comes with an all-ones code, and the zero outputs during reset. Other behaviour can only be shown by the bench scenarios, which compare against a reference queue at both clock levels and for both polarities. These are the exact 1.5-cycle latency, the edge each stage uses under each polarity, bubble suppression, and one result per cycle.

// File: rtl/flash_be_pkg.sv
package flash_be_pkg;
  localparam int DEF_CODE_W = 6;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/flash_dual_edge_reg.sv
// Register stage that can run on either clock edge; the active copy is
// picked by sel. Both copies clear on reset.
module flash_dual_edge_reg
  import flash_be_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  edge_sel_e    sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_rise;
  logic [W-1:0] q_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_rise <= '0;
    else        q_rise <= d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_fall <= '0;
    else        q_fall <= d;
  end

  assign q = (sel == EDGE_FALL) ? q_fall : q_rise;
endmodule

// File: rtl/flash_therm_encoder.sv
// Thermometer to binary: highest comparator that has a set neighbour
// below it (comparator 1 stands alone); top comparator forces overflow.
module flash_therm_encoder #(
  parameter int CODE_W = 6,
  localparam int NUM_CMP = 1 << CODE_W
) (
  input  logic [NUM_CMP-1:0] therm,
  output logic [CODE_W-1:0]  code,
  output logic               ovf
);
  logic [NUM_CMP-1:1] valid_top;
  logic [CODE_W-1:0]  raw_code;

  assign valid_top[1] = therm[0];
  for (genvar i = 2; i < NUM_CMP; i++) begin : g_pair
    assign valid_top[i] = therm[i-1] & therm[i-2];
  end

  always_comb begin
    raw_code = '0;
    for (int i = 1; i < NUM_CMP; i++) begin
      if (valid_top[i]) raw_code = CODE_W'(i);
    end
  end

  assign ovf  = therm[NUM_CMP-1];
  assign code = ovf ? '1 : raw_code;
endmodule

// File: rtl/flash_oe_decode.sv
module flash_oe_decode (
  input  logic en_n,
  input  logic en,
  output logic data_oe,
  output logic ovf_oe
);
  assign data_oe = en & ~en_n;
  assign ovf_oe  = en;
endmodule

// File: rtl/flash_adc_backend.sv
module flash_adc_backend
  import flash_be_pkg::*;
#(
  parameter int CODE_W = DEF_CODE_W,
  localparam int NUM_CMP = 1 << CODE_W,
  localparam int RES_W   = CODE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_inv,
  input  logic [NUM_CMP-1:0] therm_in,
  input  logic               drive_en_n,
  input  logic               drive_en,
  output logic [CODE_W-1:0]  code_out,
  output logic               ovf_out,
  output logic               data_oe,
  output logic               ovf_oe
);
  edge_sel_e latch_edge;
  edge_sel_e out_edge;

  assign latch_edge = sample_inv ? EDGE_FALL : EDGE_RISE;
  assign out_edge   = sample_inv ? EDGE_RISE : EDGE_FALL;

  logic [NUM_CMP-1:0] cmp_q;
  logic [CODE_W-1:0]  enc_code;
  logic               enc_ovf;
  logic [RES_W-1:0]   enc_q;
  logic [RES_W-1:0]   out_q;

  // Stage 1: comparator latch at end of sample phase
  flash_dual_edge_reg #(.W(NUM_CMP)) u_cmp_latch (
    .clk(clk), .rst_n(rst_n), .sel(latch_edge), .d(therm_in), .q(cmp_q)
  );

  flash_therm_encoder #(.CODE_W(CODE_W)) u_enc (
    .therm(cmp_q), .code(enc_code), .ovf(enc_ovf)
  );

  // Stage 2: encoded word, same edge one cycle later
  flash_dual_edge_reg #(.W(RES_W)) u_enc_reg (
    .clk(clk), .rst_n(rst_n), .sel(latch_edge), .d({enc_ovf, enc_code}), .q(enc_q)
  );

  // Stage 3: output latch, half a cycle after stage 2
  flash_dual_edge_reg #(.W(RES_W)) u_out_reg (
    .clk(clk), .rst_n(rst_n), .sel(out_edge), .d(enc_q), .q(out_q)
  );

  assign ovf_out  = out_q[RES_W-1];
  assign code_out = out_q[CODE_W-1:0];

  flash_oe_decode u_oe (
    .en_n(drive_en_n), .en(drive_en), .data_oe(data_oe), .ovf_oe(ovf_oe)
  );
endmodule

// File: rtl/flash_adc_backend_chk.sv
module flash_adc_backend_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive_en_n,
  input logic              drive_en,
  input logic [CODE_W-1:0] code_out,
  input logic              ovf_out,
  input logic              data_oe,
  input logic              ovf_oe
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (code_out == '0 && ovf_out == 1'b0)
        else $error("R1 outputs not clear in reset");
    end
  end

  p_ovf_full_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out |-> (&code_out));

  p_data_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_n || !drive_en) |-> !data_oe);

  p_data_implies_ovf_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ovf_oe);

  p_ovf_oe_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> ovf_oe);

  p_ovf_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (!ovf_oe && !data_oe));
endmodule

bind flash_adc_backend flash_adc_backend_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en_n(drive_en_n), .drive_en(drive_en),
  .code_out(code_out), .ovf_out(ovf_out), .data_oe(data_oe), .ovf_oe(ovf_oe)
);

// File: tb/tb_flash_adc_backend.sv
module tb_flash_adc_backend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        sample_inv = 1'b0;
  logic [63:0] therm_in = '0;
  logic        drive_en_n = 1'b0;
  logic        drive_en = 1'b1;
  logic [5:0]  code_out;
  logic        ovf_out;
  logic        data_oe;
  logic        ovf_oe;

  int checks = 0;
  int failures = 0;
  bit wd_hit = 1'b0;
  logic [6:0] expq[$];

  always #4 clk = ~clk;

  flash_adc_backend dut (
    .clk(clk), .rst_n(rst_n), .sample_inv(sample_inv), .therm_in(therm_in),
    .drive_en_n(drive_en_n), .drive_en(drive_en), .code_out(code_out),
    .ovf_out(ovf_out), .data_oe(data_oe), .ovf_oe(ovf_oe)
  );

  function automatic logic [6:0] ref_enc(logic [63:0] t);
    if (t[63]) return {1'b1, 6'h3F};
    for (int i = 63; i >= 1; i--) begin
      if (t[i-1] && (i == 1 || t[i-2])) return {1'b0, 6'(i)};
    end
    return 7'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_latch();
    if (sample_inv) @(negedge clk); else @(posedge clk);
  endtask

  task automatic wait_out();
    if (sample_inv) @(posedge clk); else @(negedge clk);
  endtask

  task automatic check_oe();
    chk("R7 data_oe", 32'(data_oe), 32'(!drive_en_n && drive_en));
    chk("R8 ovf_oe", 32'(ovf_oe), 32'(drive_en));
  endtask

  task automatic do_reset(bit inv);
    rst_n = 1'b0;
    therm_in = '1;
    sample_inv = inv;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 code in reset", 32'(code_out), 0);
    chk("R1 ovf in reset", 32'(ovf_out), 0);
    therm_in = '0;
    wait_out();
    #1 rst_n = 1'b1;
    expq.delete();
    expq.push_back(7'd0);
    expq.push_back(7'd0);
  endtask

  // one conversion step: t is applied before the next latch edge
  task automatic step(logic [63:0] t, string tag);
    logic [6:0] e;
    therm_in = t;
    wait_latch();
    #1;
    e = expq.pop_front();
    chk({tag, " latch-level R5/R6"}, {25'd0, ovf_out, code_out}, 32'(e));
    expq.push_back(ref_enc(t));
    wait_out();
    #1;
    chk({tag, " output-level R10"}, {25'd0, ovf_out, code_out}, 32'(expq[0]));
    // R9: enables respond with no clock edge
    drive_en_n = 1'($urandom);
    drive_en = 1'($urandom);
    #1 check_oe();
  endtask

  function automatic logic [63:0] run_of(int n);
    logic [63:0] t = '0;
    for (int j = 0; j < n; j++) t[j] = 1'b1;
    return t;
  endfunction

  task automatic flush();
    for (int k = 0; k < 3; k++) step(64'd0, "flush");
  endtask

  task automatic main();
    void'($urandom(32'd1234));
    for (int p = 0; p < 2; p++) begin
      do_reset(p[0]);
      // directed corner cases
      step(64'd0, "R2 empty");
      step(run_of(63), "R2 full no ovf");
      step(run_of(64), "R4 overflow");
      step(64'h8000_0000_0000_0000, "R4 top only");
      step(64'd1, "R2 first comparator");
      step(run_of(20) & ~(64'd1 << 10), "R3 bubble");
      step(run_of(5) | (64'd1 << 40), "R3 isolated high");
      step(run_of(37), "R2 mid run");
      step(run_of(3) & ~64'd2, "R3 low bubble");
      // random mixture, back to back
      for (int k = 0; k < 400; k++) begin
        logic [63:0] t;
        int n;
        n = $urandom_range(0, 64);
        t = run_of(n);
        if (n > 2 && ($urandom % 3) == 0) t[$urandom_range(0, n - 1)] = 1'b0;
        if (($urandom % 10) == 0) t = {$urandom, $urandom};
        step(t, p[0] ? "R6 random" : "R5 random");
      end
      flush();
    end
    // all enable pairs, directed
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        drive_en_n = a[0];
        drive_en = b[0];
        #1 check_oe();
      end
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    fork
      main();
      begin
        repeat (200000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule